// File: doc/BRIEF.md
# PWM Trip-Zone Protection Unit

This block sits between a PWM waveform generator and the two output pins of one PWM channel pair, A and B. It watches a set of fault inputs: external trip pins and digital compare events. When an enabled fault asserts, it replaces the generated waveform on each pin with a configured safe state. The choices are drive high, drive low, release the pin (high-impedance) or leave the waveform alone. The override is combinational, so a fault changes the pins in the same cycle it is seen.

Each fault source is either one-shot or cycle-by-cycle. A one-shot fault latches the trip until software issues a clear. A cycle-by-cycle fault holds the trip only until the next clear point on which that fault is no longer present. The clear point is always a counter zero-match. Optionally, a period-match also counts as a clear point. A second set of pin actions can be selected while the time-base counter counts down. A bypass input passes the waveform through untouched. Any qualified fault can also latch an interrupt flag, which stays set until software clears it.

Top module: `tz_protect`

## Requirements
- R1: Source vector bit i is `{dc_evt, trip_pin}[i]`, with the trip pins in the low bits. A source can cause a trip only while `src_en[i]` is 1. An asserted source whose enable is 0 leaves the outputs, flags and interrupt unchanged.
- R2: The pin action codes are 2'b00 no action (waveform passes), 2'b01 pin driven 1, 2'b10 pin driven 0, and 2'b11 high-impedance. For 2'b11 the hiz output is 1 and the pin value is 0. The hiz output is 0 for every other code.
- R3: While a trip is active, the selected action appears on `out_a`/`out_b`/`hiz_a`/`hiz_b` in the same cycle as the qualifying source assertion, with no register on the path.
- R4: A source with `src_cbc[i]`=0 is one-shot. A one-shot hit sets `ost_flag` on the next clock edge. The trip then persists after the source deasserts, until a cycle with `ost_clr`=1.
- R5: If a one-shot hit and `ost_clr` occur in the same cycle, the latch stays set.
- R6: A source with `src_cbc[i]`=1 is cycle-by-cycle. It sets `cbc_flag` and holds the trip until an edge at a clear point on which no cycle-by-cycle hit is present. A clear point is `zero_hit`=1, or `prd_hit`=1 when `cbc_at_prd`=1.
- R7: While `dn_sep`=1 and `cnt_down`=1, the pins use `act_a_dn`/`act_b_dn`. Otherwise they use `act_a_up`/`act_b_up`.
- R8: While `bypass`=1, `out_a`=`pwm_a`, `out_b`=`pwm_b` and both hiz outputs are 0, whatever the trip state.
- R9: With `int_en`=1, any qualified hit sets `irq` at the next edge. `irq` holds until a cycle with `int_clr`=1 and no new qualified hit. With `int_en`=0, hits do not set `irq`.
- R10: During reset, `ost_flag`, `cbc_flag` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_pin | input | N_PIN | External fault inputs, active high |
| dc_evt | input | N_DC | Digital compare fault events, active high |
| src_en | input | N_PIN+N_DC | Per-source trip enable |
| src_cbc | input | N_PIN+N_DC | Per-source mode: 1 cycle-by-cycle, 0 one-shot |
| zero_hit | input | 1 | Counter zero-match strobe |
| prd_hit | input | 1 | Counter period-match strobe |
| cbc_at_prd | input | 1 | Also clear cycle-by-cycle trips on period-match |
| cnt_down | input | 1 | Counter is counting down |
| dn_sep | input | 1 | Use the separate down-count action set |
| act_a_up | input | 2 | Pin A action, up-count or common set |
| act_b_up | input | 2 | Pin B action, up-count or common set |
| act_a_dn | input | 2 | Pin A action while counting down |
| act_b_dn | input | 2 | Pin B action while counting down |
| bypass | input | 1 | Pass waveforms through unchanged |
| ost_clr | input | 1 | Software clear of the one-shot latch |
| int_en | input | 1 | Allow trips to set the interrupt flag |
| int_clr | input | 1 | Software clear of the interrupt flag |
| pwm_a | input | 1 | Generated waveform A |
| pwm_b | input | 1 | Generated waveform B |
| out_a | output | 1 | Final pin A value |
| out_b | output | 1 | Final pin B value |
| hiz_a | output | 1 | Pin A high-impedance enable |
| hiz_b | output | 1 | Pin B high-impedance enable |
| ost_flag | output | 1 | One-shot trip latched |
| cbc_flag | output | 1 | Cycle-by-cycle trip held |
| irq | output | 1 | Interrupt flag |

## Verification
A corrupted trip latch shows up at the pins one cycle after the edge that stored it. A latch that fails to hold shows as the waveform returning while `ost_flag` drops. A cycle-by-cycle state that clears at the wrong strobe shows as the pins releasing on a period-match, or staying forced past a zero-match. A wrong action selection or a bad mask changes the pins in the same cycle as the stimulus, so every drive cycle is compared at once against a bench model of latch state and pin choice.

// File: rtl/tz_pkg.sv
package tz_pkg;

  typedef enum logic [1:0] {
    TZ_NONE = 2'b00,
    TZ_HIGH = 2'b01,
    TZ_LOW  = 2'b10,
    TZ_HIZ  = 2'b11
  } tz_act_e;

  // Returns {hiz, level} for one pin.
  function automatic logic [1:0] tz_drive(input tz_act_e act, input logic trip,
                                          input logic pwm);
    logic [1:0] r;
    r = {1'b0, pwm};
    if (trip) begin
      unique case (act)
        TZ_HIGH: r = 2'b01;
        TZ_LOW:  r = 2'b00;
        TZ_HIZ:  r = 2'b10;
        default: r = {1'b0, pwm};
      endcase
    end
    return r;
  endfunction

  function automatic tz_act_e tz_pick(input logic sep, input logic down,
                                      input tz_act_e up_act, input tz_act_e dn_act);
    return (sep && down) ? dn_act : up_act;
  endfunction

endpackage

// File: rtl/tz_src_qual.sv
module tz_src_qual #(
  parameter int N_PIN = 3,
  parameter int N_DC  = 2,
  localparam int NSRC = N_PIN + N_DC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PIN-1:0] trip_pin,
  input  logic [N_DC-1:0]  dc_evt,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_cbc,
  output logic             ost_hit,
  output logic             cbc_hit
);
  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] ost_vec;
  logic [NSRC-1:0] cbc_vec;

  assign raw = {dc_evt, trip_pin};

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic qual;
    assign qual       = raw[i] & src_en[i];
    assign ost_vec[i] = qual & ~src_cbc[i];
    assign cbc_vec[i] = qual & src_cbc[i];
  end

  assign ost_hit = |ost_vec;
  assign cbc_hit = |cbc_vec;

  // R1
  mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & src_en) == '0) |-> !(ost_hit || cbc_hit));

endmodule

// File: rtl/tz_latch.sv
module tz_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ost_hit,
  input  logic cbc_hit,
  input  logic ost_clr,
  input  logic zero_hit,
  input  logic prd_hit,
  input  logic cbc_at_prd,
  input  logic int_en,
  input  logic int_clr,
  output logic ost_q,
  output logic cbc_q,
  output logic irq_q,
  output logic clr_pt
);
  assign clr_pt = zero_hit | (cbc_at_prd & prd_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ost_q <= 1'b0;
      cbc_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (ost_hit)      ost_q <= 1'b1;
      else if (ost_clr) ost_q <= 1'b0;

      if (cbc_hit)     cbc_q <= 1'b1;
      else if (clr_pt) cbc_q <= 1'b0;

      if (int_en && (ost_hit || cbc_hit)) irq_q <= 1'b1;
      else if (int_clr)                   irq_q <= 1'b0;
    end
  end

  // R4
  ost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ost_q && !ost_clr) |=> ost_q);

  // R5
  ost_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ost_hit |=> ost_q);

  // R6
  cbc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_q && clr_pt && !cbc_hit) |=> !cbc_q);

  // R6
  cbc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cbc_q && !clr_pt) |=> cbc_q);

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !int_clr) |=> irq_q);

endmodule

// File: rtl/tz_override.sv
module tz_override
  import tz_pkg::*;
(
  input  logic       trip,
  input  logic       bypass,
  input  logic       down,
  input  logic       dn_sep,
  input  logic [1:0] act_up,
  input  logic [1:0] act_dn,
  input  logic       pwm,
  output logic       pin,
  output logic       hiz,
  output tz_act_e    act_eff
);
  logic [1:0] drv;

  assign act_eff = tz_pick(dn_sep, down, tz_act_e'(act_up), tz_act_e'(act_dn));
  assign drv     = tz_drive(act_eff, trip & ~bypass, pwm);
  assign hiz     = drv[1];
  assign pin     = drv[0];

endmodule

// File: rtl/tz_protect.sv
module tz_protect
  import tz_pkg::*;
#(
  parameter int N_PIN = 3,
  parameter int N_DC  = 2,
  localparam int NSRC = N_PIN + N_DC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] trip_pin,
  input  logic [N_DC-1:0]  dc_evt,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC-1:0]  src_cbc,
  input  logic             zero_hit,
  input  logic             prd_hit,
  input  logic             cbc_at_prd,
  input  logic             cnt_down,
  input  logic             dn_sep,
  input  logic [1:0]       act_a_up,
  input  logic [1:0]       act_b_up,
  input  logic [1:0]       act_a_dn,
  input  logic [1:0]       act_b_dn,
  input  logic             bypass,
  input  logic             ost_clr,
  input  logic             int_en,
  input  logic             int_clr,
  input  logic             pwm_a,
  input  logic             pwm_b,
  output logic             out_a,
  output logic             out_b,
  output logic             hiz_a,
  output logic             hiz_b,
  output logic             ost_flag,
  output logic             cbc_flag,
  output logic             irq
);
  localparam int NCH = 2;

  logic ost_hit_w, cbc_hit_w;
  logic ost_q, cbc_q, irq_q, clr_pt_w;
  logic trip_now;

  logic [1:0] up_arr  [NCH];
  logic [1:0] dn_arr  [NCH];
  logic       pwm_arr [NCH];
  logic       pin_arr [NCH];
  logic       hiz_arr [NCH];
  tz_act_e    act_arr [NCH];

  tz_src_qual #(.N_PIN(N_PIN), .N_DC(N_DC)) u_qual (
    .clk(clk), .rst_n(rst_n),
    .trip_pin(trip_pin), .dc_evt(dc_evt),
    .src_en(src_en), .src_cbc(src_cbc),
    .ost_hit(ost_hit_w), .cbc_hit(cbc_hit_w)
  );

  tz_latch u_latch (
    .clk(clk), .rst_n(rst_n),
    .ost_hit(ost_hit_w), .cbc_hit(cbc_hit_w),
    .ost_clr(ost_clr), .zero_hit(zero_hit), .prd_hit(prd_hit),
    .cbc_at_prd(cbc_at_prd), .int_en(int_en), .int_clr(int_clr),
    .ost_q(ost_q), .cbc_q(cbc_q), .irq_q(irq_q), .clr_pt(clr_pt_w)
  );

  assign trip_now = ost_hit_w | cbc_hit_w | ost_q | cbc_q;

  assign up_arr[0]  = act_a_up;
  assign up_arr[1]  = act_b_up;
  assign dn_arr[0]  = act_a_dn;
  assign dn_arr[1]  = act_b_dn;
  assign pwm_arr[0] = pwm_a;
  assign pwm_arr[1] = pwm_b;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tz_override u_ovr (
      .trip(trip_now), .bypass(bypass), .down(cnt_down), .dn_sep(dn_sep),
      .act_up(up_arr[c]), .act_dn(dn_arr[c]), .pwm(pwm_arr[c]),
      .pin(pin_arr[c]), .hiz(hiz_arr[c]), .act_eff(act_arr[c])
    );
  end

  assign out_a    = pin_arr[0];
  assign out_b    = pin_arr[1];
  assign hiz_a    = hiz_arr[0];
  assign hiz_b    = hiz_arr[1];
  assign ost_flag = ost_q;
  assign cbc_flag = cbc_q;
  assign irq      = irq_q;

  // R3
  same_cycle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && (ost_hit_w || cbc_hit_w) && act_arr[0] == TZ_HIZ) |-> hiz_a);

  // R3
  same_cycle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && (ost_hit_w || cbc_hit_w) && act_arr[1] == TZ_HIGH) |-> (out_b && !hiz_b));

  // R8
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (out_a == pwm_a && out_b == pwm_b && !hiz_a && !hiz_b));

  // R2
  no_trip_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ost_flag && !cbc_flag && !ost_hit_w && !cbc_hit_w) |-> (out_a == pwm_a && !hiz_a));

endmodule

// File: tb/sim_tz_protect.sv
module sim_tz_protect;
  localparam int N_PIN = 3;
  localparam int N_DC  = 2;
  localparam int NSRC  = N_PIN + N_DC;

  typedef struct packed {
    logic [N_PIN-1:0] pin;
    logic [N_DC-1:0]  dc;
    logic [NSRC-1:0]  en;
    logic [NSRC-1:0]  cbc;
    logic zero, prd, at_prd, down, sep;
    logic [1:0] aup, bup, adn, bdn;
    logic byp, oclr, ien, iclr, pa, pb;
  } stim_t;

  typedef struct {
    int   req;
    logic a, b, az, bz, of, cf, ir;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  stim_t s, d;
  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic m_ost = 0, m_cbc = 0, m_irq = 0;

  logic out_a, out_b, hiz_a, hiz_b, ost_flag, cbc_flag, irq;

  always #4 clk = ~clk;

  tz_protect #(.N_PIN(N_PIN), .N_DC(N_DC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .trip_pin(d.pin), .dc_evt(d.dc), .src_en(d.en), .src_cbc(d.cbc),
    .zero_hit(d.zero), .prd_hit(d.prd), .cbc_at_prd(d.at_prd),
    .cnt_down(d.down), .dn_sep(d.sep),
    .act_a_up(d.aup), .act_b_up(d.bup), .act_a_dn(d.adn), .act_b_dn(d.bdn),
    .bypass(d.byp), .ost_clr(d.oclr), .int_en(d.ien), .int_clr(d.iclr),
    .pwm_a(d.pa), .pwm_b(d.pb),
    .out_a(out_a), .out_b(out_b), .hiz_a(hiz_a), .hiz_b(hiz_b),
    .ost_flag(ost_flag), .cbc_flag(cbc_flag), .irq(irq)
  );

  // Pin model restated as a lookup on the code value.
  function automatic logic [1:0] pin_model(input logic [1:0] code, input logic tripped,
                                           input logic wave);
    if (!tripped || code == 2'b00) return {1'b0, wave};
    if (code == 2'b01) return 2'b01;
    if (code == 2'b10) return 2'b00;
    return 2'b10;
  endfunction

  task automatic chk(input int req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Driver: apply staged stimulus, push expectation, advance model.
  task automatic apply(input int req);
    logic oh, ch, tr;
    logic [NSRC-1:0] rawv;
    logic [1:0] ca, cb, pa, pb;
    exp_t e;
    @(negedge clk);
    d = s;
    rawv = {s.dc, s.pin} & s.en;
    oh = |(rawv & ~s.cbc);
    ch = |(rawv & s.cbc);
    tr = (oh | ch | m_ost | m_cbc) & ~s.byp;
    ca = (s.sep & s.down) ? s.adn : s.aup;
    cb = (s.sep & s.down) ? s.bdn : s.bup;
    pa = pin_model(ca, tr, s.pa);
    pb = pin_model(cb, tr, s.pb);
    e.req = req; e.a = pa[0]; e.az = pa[1]; e.b = pb[0]; e.bz = pb[1];
    e.of = m_ost; e.cf = m_cbc; e.ir = m_irq;
    q.push_back(e);
    m_ost = oh | (m_ost & ~s.oclr);
    m_cbc = ch | (m_cbc & ~(s.zero | (s.at_prd & s.prd)));
    m_irq = (s.ien & (oh | ch)) | (m_irq & ~s.iclr);
  endtask

  // Monitor: pop and compare away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(e.req, "out_a", out_a, e.a);
        chk(e.req, "hiz_a", hiz_a, e.az);
        chk(e.req, "out_b", out_b, e.b);
        chk(e.req, "hiz_b", hiz_b, e.bz);
        chk(e.req, "ost_flag", ost_flag, e.of);
        chk(e.req, "cbc_flag", cbc_flag, e.cf);
        chk(e.req, "irq", irq, e.ir);
      end
    end
  end

  initial begin
    #(8 * 5000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    s = '0;
    d = '0;
    s.pa = 1'b1; s.pb = 1'b0;
    d = s;
    repeat (3) @(negedge clk);
    // R10: flags clear while held in reset
    chk(10, "ost_flag in reset", ost_flag, 1'b0);
    chk(10, "cbc_flag in reset", cbc_flag, 1'b0);
    chk(10, "irq in reset", irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(10);

    // R1: source asserted but mask off -> pass through
    s.pin = 3'b001; s.aup = 2'b10; s.bup = 2'b01; s.ien = 1'b1;
    apply(1);
    s.dc = 2'b10;
    apply(1);
    s.pin = '0; s.dc = '0;
    apply(1);

    // R3 R2: one-shot on pin0, A->hiz, B->high, same cycle
    s.en = 5'b00001; s.aup = 2'b11; s.bup = 2'b01;
    s.pin = 3'b001;
    apply(3);
    // R4: deasserted, stays latched
    s.pin = '0;
    apply(4);
    apply(4);
    // R2: change codes while latched: A low, B none
    s.aup = 2'b10; s.bup = 2'b00;
    apply(2);
    s.pa = 1'b0; s.pb = 1'b1; s.aup = 2'b01;
    apply(2);
    // R5: clear together with a fresh hit keeps latch
    s.pin = 3'b001; s.oclr = 1'b1;
    apply(5);
    s.pin = '0;
    apply(4);
    s.oclr = 1'b0;
    apply(4);
    apply(4);

    // R9: irq held; clear it
    s.iclr = 1'b1;
    apply(9);
    s.iclr = 1'b0; s.ien = 1'b0;
    apply(9);

    // R6: cycle-by-cycle on pin1
    s.en = 5'b00010; s.cbc = 5'b00010; s.aup = 2'b01; s.bup = 2'b10; s.pa = 1'b0; s.pb = 1'b1;
    s.pin = 3'b010;
    apply(6);
    s.pin = '0;
    apply(6);
    s.prd = 1'b1;       // period strobe ignored with cbc_at_prd=0
    apply(6);
    s.prd = 1'b0;
    apply(6);
    s.pin = 3'b010; s.zero = 1'b1;  // zero while still asserted: held
    apply(6);
    s.pin = '0; s.zero = 1'b0;
    apply(6);
    s.at_prd = 1'b1; s.prd = 1'b1;  // period strobe now clears
    apply(6);
    s.prd = 1'b0;
    apply(6);
    apply(6);
    s.at_prd = 1'b0;
    s.pin = 3'b010;
    apply(6);
    s.pin = '0; s.zero = 1'b1;      // zero-match clears
    apply(6);
    s.zero = 1'b0;
    apply(6);

    // R7: down-count action set, dc event source as cbc
    s.en = 5'b01000; s.cbc = 5'b01000; s.dc = 2'b01;
    s.aup = 2'b01; s.bup = 2'b01; s.adn = 2'b10; s.bdn = 2'b11;
    s.down = 1'b1; s.sep = 1'b0;
    apply(7);
    s.sep = 1'b1;
    apply(7);
    s.down = 1'b0;
    apply(7);
    s.down = 1'b1;
    apply(7);

    // R8: bypass passes through while tripped
    s.byp = 1'b1; s.pa = 1'b1; s.pb = 1'b1;
    apply(8);
    s.pa = 1'b0;
    apply(8);
    s.byp = 1'b0;
    apply(8);

    // R9: irq set with enable, hold and set-wins over clear
    s.dc = '0; s.zero = 1'b1;
    apply(9);
    s.zero = 1'b0; s.ien = 1'b1; s.pin = '0; s.dc = 2'b01;
    apply(9);
    s.dc = '0;
    apply(9);
    s.dc = 2'b01; s.iclr = 1'b1;
    apply(9);
    s.dc = '0;
    apply(9);
    s.iclr = 1'b0; s.zero = 1'b1;
    apply(9);
    s.zero = 1'b0;
    apply(9);
    apply(9);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule